// File: doc/BRIEF.md
# Transfer-Service Completion Interrupt Controller

This block sits between up to fifteen interrupt sources and the CPU. Each source runs in one of two modes. In transfer mode an event is counted as a data-transfer request. In normal mode an event becomes an ordinary pending interrupt. Software picks the mode by setting a per-source select bit and loading a per-source 16-bit transfer counter.

While a source is in transfer mode, each event decrements its counter and emits a one-cycle transfer strobe carrying that channel's transfer vector. When the counter runs out, the block does two things on one edge: it drops the source back to normal mode, and it latches a service-done flag. The done flag requests a completion interrupt on the source's standard vector. The block never re-enables the channel by itself, so software must re-arm it.

Pending normal requests and done flags are merged per source. The highest-numbered requesting source is presented to the CPU as a request line plus a vector. An acknowledge retires both the done flag and the pending flag of the presented source. A parameter can retire sources 10 to 12 entirely.

Top module: `xfer_irq_ctrl`

## Requirements
- R1: Bus registers sit at these addresses: select register at 04H (read/write), done register at 06H, pending register at 08H (read only), and counter n at 20H+2n (read/write). Read data appears on `bus_rdata` at the edge after `bus_rd`. All registers reset to 0. Bit 15 of the done register always reads 0.
- R2: An event on a source whose select bit is 1 decrements that source's counter by one.
- R3: Each cycle in which any transfer-mode source gets an event is followed by a one-cycle `xfer_go` pulse. `xfer_vec` then holds 2040H+2n, where n is the highest such source.
- R4: An event that arrives while the select bit is 1 and the counter is 1 or 0 does the following on the same edge: it clears the select bit, sets the done bit, and leaves the counter at 0. The counter never wraps.
- R5: An event on a source whose select bit is 0 sets that source's pending bit. It does not touch the counter and gives no `xfer_go`.
- R6: `irq_req` is high exactly when some done or pending bit is set. `irq_vec` is then 2000H+2n for the highest-numbered such source n. A done request and a pending request of the same source use the same vector.
- R7: A cycle with `irq_ack` high while `irq_req` is high clears both the done bit and the pending bit of the presented source.
- R8: Writing the done register clears each bit written as 1 and leaves bits written as 0 unchanged. A write can never set a bit. If a hardware completion and a software clear hit the same bit on the same edge, the bit ends up set.
- R9: A select bit becomes 1 only through a bus write to the select register. It stays 0 after completion until that write.
- R10: With `RSV_MID`=1, the select, done and pending bits 10 to 12 stay 0. Events on those sources raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_evt | input | 15 | Per-source event pulses |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec | output | 16 | Vector of presented source |
| irq_ack | input | 1 | CPU takes presented interrupt |
| xfer_go | output | 1 | Transfer request strobe |
| xfer_vec | output | 16 | Transfer vector of strobed channel |

## Verification
Stimulus comes in four kinds. Single events on a normal-mode source separate the pending path from the counter path. Runs of events on an armed channel take its counter from a loaded value down to exhaustion, showing the decrement, the completion edge and the automatic disarm. Simultaneous events on several sources check priority, both in the transfer vector and in the interrupt vector across successive acknowledges. Colliding bus writes and completions on one edge, together with a second instance with the reserved range enabled, separate the precedence rules and the masking from the ordinary cases.

// File: rtl/xic_pkg.sv
package xic_pkg;
  localparam int unsigned XIC_ADDR_W = 8;
  localparam int unsigned XIC_DATA_W = 16;
  localparam logic [XIC_ADDR_W-1:0] XIC_A_SEL  = 8'h04;
  localparam logic [XIC_ADDR_W-1:0] XIC_A_DONE = 8'h06;
  localparam logic [XIC_ADDR_W-1:0] XIC_A_PEND = 8'h08;
  localparam logic [XIC_ADDR_W-1:0] XIC_A_CNT  = 8'h20;

  typedef enum logic [1:0] {
    RSRC_SEL  = 2'd0,
    RSRC_DONE = 2'd1,
    RSRC_PEND = 2'd2,
    RSRC_CNT  = 2'd3
  } rsrc_e;
endpackage

// File: rtl/xic_chan.sv
module xic_chan #(
  parameter int unsigned CNT_W = 16,
  parameter bit          RSV   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             sel_we_i,
  input  logic             sel_wd_i,
  input  logic             done_w1c_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  input  logic             ack_clr_i,
  output logic             sel_o,
  output logic             done_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_next_o,
  output logic             hit_o
);
  generate
    if (RSV) begin : g_rsv
      logic unused_chan;
      assign unused_chan = ^{clk, rst, evt_i, sel_we_i, sel_wd_i, done_w1c_i,
                             cnt_we_i, cnt_wd_i, ack_clr_i};
      assign sel_o      = 1'b0;
      assign done_o     = 1'b0;
      assign pend_o     = 1'b0;
      assign cnt_o      = '0;
      assign req_next_o = 1'b0;
      assign hit_o      = 1'b0;
    end else begin : g_live
      logic             sel_q, done_q, pend_q;
      logic [CNT_W-1:0] cnt_q;
      logic             sel_d, done_d, pend_d, last;
      logic [CNT_W-1:0] cnt_d;

      always_comb begin
        hit_o = evt_i & sel_q;
        last  = hit_o & (cnt_q <= CNT_W'(1));
        sel_d = sel_we_i ? sel_wd_i : sel_q;
        if (last) sel_d = 1'b0;
        cnt_d = cnt_q;
        if (hit_o && (cnt_q != '0)) cnt_d = cnt_q - CNT_W'(1);
        if (cnt_we_i) cnt_d = cnt_wd_i;
        done_d = (done_q & ~(done_w1c_i | ack_clr_i)) | last;
        pend_d = (pend_q & ~ack_clr_i) | (evt_i & ~sel_q);
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          sel_q  <= 1'b0;
          done_q <= 1'b0;
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          sel_q  <= sel_d;
          done_q <= done_d;
          pend_q <= pend_d;
          cnt_q  <= cnt_d;
        end
      end

      assign sel_o      = sel_q;
      assign done_o     = done_q;
      assign pend_o     = pend_q;
      assign cnt_o      = cnt_q;
      assign req_next_o = done_d | pend_d;

      AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $fell(sel_q)) else $error("done without disarm"); // R4
      AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !cnt_we_i) |=> cnt_q == '0) else $error("counter wrapped"); // R4
      AST_NO_SELF_ARM: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && !(sel_we_i && sel_wd_i)) |=> !sel_q) else $error("select set by hardware"); // R9
      AST_NORMAL_PEND: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !sel_q) |=> pend_q) else $error("normal event lost"); // R5
    end
  endgenerate
endmodule

// File: rtl/xic_regs.sv
module xic_regs
  import xic_pkg::*;
#(
  parameter int unsigned N     = 15,
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [XIC_ADDR_W-1:0]   bus_addr,
  input  logic [XIC_DATA_W-1:0]   bus_wdata,
  output logic [XIC_DATA_W-1:0]   bus_rdata,
  input  logic [N-1:0]            sel_i,
  input  logic [N-1:0]            done_i,
  input  logic [N-1:0]            pend_i,
  input  logic [N*CNT_W-1:0]      cnt_flat_i,
  output logic                    sel_we_o,
  output logic [N-1:0]            sel_wd_o,
  output logic [N-1:0]            done_w1c_o,
  output logic [N-1:0]            cnt_we_o,
  output logic [CNT_W-1:0]        cnt_wd_o
);
  localparam int unsigned IDX_W = XIC_ADDR_W - 1;

  logic [XIC_ADDR_W-1:0] off;
  logic [IDX_W-1:0]      cnt_idx;
  logic                  cnt_hit;
  rsrc_e                 rsrc;
  logic                  rsrc_ok;
  logic [XIC_DATA_W-1:0] rd_d;
  logic                  rd_done_q;

  always_comb begin
    off     = bus_addr - XIC_A_CNT;
    cnt_idx = off[XIC_ADDR_W-1:1];
    cnt_hit = (bus_addr >= XIC_A_CNT) && !off[0] && (32'(cnt_idx) < N);
    rsrc_ok = 1'b1;
    rsrc    = RSRC_SEL;
    if (bus_addr == XIC_A_SEL)       rsrc = RSRC_SEL;
    else if (bus_addr == XIC_A_DONE) rsrc = RSRC_DONE;
    else if (bus_addr == XIC_A_PEND) rsrc = RSRC_PEND;
    else if (cnt_hit)                rsrc = RSRC_CNT;
    else                             rsrc_ok = 1'b0;
  end

  always_comb begin
    sel_we_o   = bus_wr && rsrc_ok && (rsrc == RSRC_SEL);
    sel_wd_o   = bus_wdata[N-1:0];
    done_w1c_o = (bus_wr && rsrc_ok && (rsrc == RSRC_DONE)) ? bus_wdata[N-1:0] : '0;
    cnt_wd_o   = bus_wdata[CNT_W-1:0];
    for (int i = 0; i < N; i++)
      cnt_we_o[i] = bus_wr && rsrc_ok && (rsrc == RSRC_CNT) && (32'(cnt_idx) == i);
  end

  always_comb begin
    rd_d = '0;
    if (rsrc_ok) begin
      case (rsrc)
        RSRC_SEL:  rd_d = XIC_DATA_W'(sel_i);
        RSRC_DONE: rd_d = XIC_DATA_W'(done_i);
        RSRC_PEND: rd_d = XIC_DATA_W'(pend_i);
        default:   rd_d = XIC_DATA_W'(cnt_flat_i[32'(cnt_idx)*CNT_W +: CNT_W]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_done_q <= 1'b0;
    end else begin
      rd_done_q <= bus_rd && rsrc_ok && (rsrc == RSRC_DONE);
      if (bus_rd) bus_rdata <= rd_d;
    end
  end

  AST_DONE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_done_q |-> bus_rdata[XIC_DATA_W-1] == 1'b0) else $error("done bit 15 set"); // R1
endmodule

// File: rtl/xic_arb.sv
module xic_arb #(
  parameter int unsigned N         = 15,
  parameter int unsigned VEC_W     = 16,
  parameter logic [15:0] STD_BASE  = 16'h2000,
  parameter logic [15:0] XFER_BASE = 16'h2040,
  localparam int unsigned ID_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     hit_i,
  output logic             irq_req_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             xfer_go_o,
  output logic [VEC_W-1:0] xfer_vec_o
);
  logic [ID_W-1:0] req_win, hit_win;

  always_comb begin
    req_win = '0;
    hit_win = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) req_win = ID_W'(i);
      if (hit_i[i]) hit_win = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_o  <= 1'b0;
      irq_id_o   <= '0;
      irq_vec_o  <= '0;
      xfer_go_o  <= 1'b0;
      xfer_vec_o <= '0;
    end else begin
      irq_req_o  <= |req_i;
      irq_id_o   <= req_win;
      irq_vec_o  <= VEC_W'(STD_BASE) + (VEC_W'(req_win) << 1);
      xfer_go_o  <= |hit_i;
      xfer_vec_o <= VEC_W'(XFER_BASE) + (VEC_W'(hit_win) << 1);
    end
  end

  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    (hit_i == '0) |=> !xfer_go_o) else $error("spurious transfer strobe"); // R3
endmodule

// File: rtl/xfer_irq_ctrl.sv
module xfer_irq_ctrl
  import xic_pkg::*;
#(
  parameter int unsigned N         = 15,
  parameter int unsigned CNT_W     = 16,
  parameter bit          RSV_MID   = 1'b0,
  parameter int unsigned RSV_LO    = 10,
  parameter int unsigned RSV_HI    = 12,
  parameter logic [15:0] STD_BASE  = 16'h2000,
  parameter logic [15:0] XFER_BASE = 16'h2040
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [14:0] src_evt,
  output logic        irq_req,
  output logic [15:0] irq_vec,
  input  logic        irq_ack,
  output logic        xfer_go,
  output logic [15:0] xfer_vec
);
  localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]       sel, done, pend, req_next, hit, ack_clr;
  logic [N-1:0]       sel_wd, done_w1c, cnt_we;
  logic               sel_we;
  logic [CNT_W-1:0]   cnt_wd;
  logic [N*CNT_W-1:0] cnt_flat;
  logic [ID_W-1:0]    irq_id;
  logic [N-1:0]       req_state;

  xic_regs #(.N(N), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_i(sel), .done_i(done), .pend_i(pend), .cnt_flat_i(cnt_flat),
    .sel_we_o(sel_we), .sel_wd_o(sel_wd), .done_w1c_o(done_w1c),
    .cnt_we_o(cnt_we), .cnt_wd_o(cnt_wd)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_ch
      localparam bit IS_RSV = RSV_MID && (g >= RSV_LO) && (g <= RSV_HI);
      assign ack_clr[g] = irq_ack && irq_req && (32'(irq_id) == g);
      xic_chan #(.CNT_W(CNT_W), .RSV(IS_RSV)) u_chan (
        .clk(clk), .rst(rst), .evt_i(src_evt[g]),
        .sel_we_i(sel_we), .sel_wd_i(sel_wd[g]), .done_w1c_i(done_w1c[g]),
        .cnt_we_i(cnt_we[g]), .cnt_wd_i(cnt_wd), .ack_clr_i(ack_clr[g]),
        .sel_o(sel[g]), .done_o(done[g]), .pend_o(pend[g]),
        .cnt_o(cnt_flat[g*CNT_W +: CNT_W]),
        .req_next_o(req_next[g]), .hit_o(hit[g])
      );
      if (IS_RSV) begin : g_rsv_chk
        AST_RSV_QUIET: assert property (@(posedge clk) disable iff (rst)
          !(sel[g] || done[g] || pend[g])) else $error("reserved source active"); // R10
      end
    end
  endgenerate

  xic_arb #(.N(N), .VEC_W(16), .STD_BASE(STD_BASE), .XFER_BASE(XFER_BASE)) u_arb (
    .clk(clk), .rst(rst), .req_i(req_next), .hit_i(hit),
    .irq_req_o(irq_req), .irq_id_o(irq_id), .irq_vec_o(irq_vec),
    .xfer_go_o(xfer_go), .xfer_vec_o(xfer_vec)
  );

  assign req_state = done | pend;

  AST_REQ_MATCHES: assert property (@(posedge clk) disable iff (rst)
    irq_req == (req_state != '0)) else $error("request line mismatch"); // R6
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((req_state >> irq_id) & N'(1)) != '0) else $error("winner not pending"); // R6
  AST_NONE_HIGHER: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((req_state >> irq_id) >> 1) == '0) else $error("higher source skipped"); // R6
  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && !src_evt[irq_id]) |=> !req_state[$past(irq_id)])
    else $error("ack left source pending"); // R7
endmodule

// File: tb/xfer_irq_ctrl_bench.sv
module xfer_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [14:0] src_evt = '0;
  logic        irq_ack = 1'b0;
  logic [15:0] bus_rdata, irq_vec, xfer_vec;
  logic        irq_req, xfer_go;
  logic [15:0] bus_rdata2, irq_vec2, xfer_vec2;
  logic        irq_req2, xfer_go2;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_irq_ctrl u_xfer_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .xfer_go(xfer_go), .xfer_vec(xfer_vec));

  xfer_irq_ctrl #(.RSV_MID(1'b1)) u_xfer_irq_ctrl_rsv (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata2), .src_evt(src_evt),
    .irq_req(irq_req2), .irq_vec(irq_vec2), .irq_ack(irq_ack),
    .xfer_go(xfer_go2), .xfer_vec(xfer_vec2));

  // monitor: one registered read result per read strobe
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic evt(input logic [14:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({15'd0, irq_req}, 16'd0, "R6 reset req");
    chk({15'd0, xfer_go}, 16'd0, "R3 reset go");
    rd(8'h06, 16'h0000, "R1 done reset");
    rd(8'h04, 16'h0000, "R1 sel reset");

    // R10: reserved range on the second instance
    wr(8'h04, 16'h1C00);
    rd(8'h04, 16'h1C00, "R1 sel write");
    chk(bus_rdata2, 16'h0000, "R10 reserved sel");
    wr(8'h04, 16'h0000);
    evt(15'h0800);
    chk({15'd0, irq_req}, 16'd1, "R5 src11 req");
    chk(irq_vec, 16'h2016, "R6 src11 vec");
    chk({15'd0, irq_req2}, 16'd0, "R10 reserved no req");
    rd(8'h08, 16'h0800, "R5 pend src11");
    chk(bus_rdata2, 16'h0000, "R10 reserved pend");
    ack();
    chk({15'd0, irq_req}, 16'd0, "R7 ack clears");

    // R5 normal routing
    evt(15'h0008);
    chk(irq_vec, 16'h2006, "R6 src3 vec");
    chk({15'd0, xfer_go}, 16'd0, "R5 no transfer");
    rd(8'h08, 16'h0008, "R5 pend src3");
    ack();
    chk({15'd0, irq_req}, 16'd0, "R7 src3 retired");
    rd(8'h08, 16'h0000, "R7 pend cleared");

    // R2/R3/R4 count down on source 5
    wr(8'h2A, 16'd3);
    wr(8'h04, 16'h0020);
    rd(8'h2A, 16'd3, "R1 counter write");
    evt(15'h0020);
    chk({15'd0, xfer_go}, 16'd1, "R3 go src5");
    chk(xfer_vec, 16'h204A, "R3 vec src5");
    chk({15'd0, irq_req}, 16'd0, "R2 no irq yet");
    rd(8'h2A, 16'd2, "R2 decrement");
    evt(15'h0020);
    evt(15'h0020);
    chk({15'd0, irq_req}, 16'd1, "R4 completion req");
    chk(irq_vec, 16'h200A, "R6 completion vec");
    rd(8'h04, 16'h0000, "R4 sel cleared");
    rd(8'h06, 16'h0020, "R4 done set");
    rd(8'h2A, 16'h0000, "R4 count zero");
    repeat (3) @(negedge clk);
    rd(8'h04, 16'h0000, "R9 stays disarmed");
    evt(15'h0020);
    chk({15'd0, xfer_go}, 16'd0, "R5 disarmed no go");
    rd(8'h08, 16'h0020, "R5 disarmed to pend");
    rd(8'h2A, 16'h0000, "R5 counter untouched");
    chk(irq_vec, 16'h200A, "R6 merged vec");
    ack();
    chk({15'd0, irq_req}, 16'd0, "R7 merged retire");
    rd(8'h06, 16'h0000, "R7 done cleared");
    rd(8'h08, 16'h0000, "R7 pend cleared");

    // R4 armed with zero count
    wr(8'h28, 16'd0);
    wr(8'h04, 16'h0010);
    evt(15'h0010);
    rd(8'h06, 16'h0010, "R4 zero-count done");
    rd(8'h28, 16'h0000, "R4 no wrap");
    rd(8'h04, 16'h0000, "R4 zero-count disarm");

    // R8 write-one-to-clear
    wr(8'h06, 16'hFFEF);
    rd(8'h06, 16'h0010, "R8 zeros ignored");
    wr(8'h06, 16'h0010);
    rd(8'h06, 16'h0000, "R8 one clears");
    chk({15'd0, irq_req}, 16'd0, "R8 no req after clear");
    wr(8'h06, 16'hFFFF);
    rd(8'h06, 16'h0000, "R8 cannot set, R1 bit15");

    // R8 hardware set beats software clear
    wr(8'h24, 16'd1);
    wr(8'h04, 16'h0004);
    src_evt = 15'h0004; bus_wr = 1'b1; bus_addr = 8'h06; bus_wdata = 16'h0004;
    @(negedge clk);
    src_evt = '0; bus_wr = 1'b0;
    rd(8'h06, 16'h0004, "R8 hw set wins");
    ack();

    // R6 priority across acknowledges
    evt(15'h4202);
    chk(irq_vec, 16'h201C, "R6 prio 14");
    ack();
    chk(irq_vec, 16'h2012, "R6 prio 9");
    ack();
    chk(irq_vec, 16'h2002, "R6 prio 1");
    ack();
    chk({15'd0, irq_req}, 16'd0, "R7 all retired");

    // R3 transfer vectors at both ends
    wr(8'h20, 16'd5);
    wr(8'h3C, 16'd5);
    wr(8'h04, 16'h4001);
    evt(15'h4001);
    chk(xfer_vec, 16'h205C, "R3 vec src14");
    evt(15'h0001);
    chk(xfer_vec, 16'h2040, "R3 vec src0");
    @(negedge clk);
    chk({15'd0, xfer_go}, 16'd0, "R3 single pulse");

    @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule